// File: doc/BRIEF.md
# Master-Clock Ratio and Word-Clock Sync Monitor

This block sits on the master clock of an audio converter pair. It works out whether the master clock runs at 256, 384 or 512 times the sample rate by counting master clocks across each word-clock period. From the detected ratio it produces a one-cycle enable at the 256fS rate. It also runs the reset sequence after power comes up or the reset pin is released. Until that sequence is complete, and whenever word-clock synchronization is lost, it holds the DAC at midscale and the ADC output at zero.

Lock is gained after two consecutive word-clock periods that agree on the same ratio. Once locked, a period may deviate from the nominal length by a number of bit clocks up to a tolerance; the bit-clock length is measured on the fly. A larger deviation, or a word-clock edge that arrives too late, drops the lock. The word and bit clocks are expected to be synchronous to the master clock already. Power detection is outside the block; a power-good input stands in for it.

Top module: `mclk_ratio_sync`

## Requirements
- R1: `int_rst_n` goes low at once while `power_good` or `rst_pin_n` is low, and rises exactly INIT_CYCLES master-clock rising edges after both are high; once high it stays high until one of them drops.
- R2: While `int_rst_n` is low: `dac_force_mid`=1, `adc_force_zero`=1, `ratio_code`=0 and `en_256fs`=0.
- R3: A word-clock period is measured as the count of master-clock edges between word-clock rising edges. It is classified as code 1 (256), code 2 (384) or code 3 (512) when within ±MATCH_TOL of that length, and as code 0 otherwise. A stream of unclassifiable periods never produces a lock. With defaults, 258 locks and 259 does not.
- R4: `ratio_code` takes the detected code at the second consecutive period with the same code. `sync_ok` rises, and `dac_force_mid` falls, only at the next word-clock rising edge after that.
- R5: `adc_force_zero` stays high until ADC_FRAMES word-clock rising edges have been seen since `int_rst_n` rose. It is also high whenever `dac_force_mid` is high.
- R6: While locked, a period that differs from the nominal length by at most DRIFT_BITS measured bit-clock periods keeps the lock. A larger difference clears `ratio_code` to 0 and `sync_ok`, reasserts both force outputs, and pulses `sync_lost` for exactly one cycle.
- R7: While locked, loss is declared at the first master-clock edge at which the running period exceeds nominal plus the drift limit. This happens without waiting for the late word-clock edge.
- R8: `en_256fs` is high every cycle for code 1, two cycles of every three for code 2, every other cycle for code 3, and never for code 0. After a code change the pattern restarts, with `en_256fs` high in the first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| power_good | input | 1 | High when supply is valid; low forces reset |
| rst_pin_n | input | 1 | Reset pin, active low, asynchronous |
| lrck | input | 1 | Word clock, synchronous to mclk |
| bck | input | 1 | Bit clock, synchronous to mclk |
| ratio_code | output | 2 | Detected ratio: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| en_256fs | output | 1 | Enable pulse at the 256fS rate |
| int_rst_n | output | 1 | Internal reset, active low |
| dac_force_mid | output | 1 | Holds DAC outputs at midscale |
| adc_force_zero | output | 1 | Holds ADC output words at zero |
| sync_ok | output | 1 | Word clock locked and forces released |
| sync_lost | output | 1 | One-cycle pulse when lock is dropped |

## Verification
The bench builds the block with INIT_CYCLES=16 and ADC_FRAMES=8, and keeps MATCH_TOL=2 and DRIFT_BITS=5. With these values the exact reset-release edge and the ADC hold, which ends after the DAC release, both fall within a few word-clock frames. The tolerance and drift edges are tested at their production values: bit clocks of 4, 6 and 8 master clocks give drift limits of 20, 30 and 40 cycles, and 20-cycle and 24-cycle phase jumps probe both sides of the limit.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  localparam int RATIO_MAX_LEN = 512;
  localparam int CNT_W = $clog2(4 * RATIO_MAX_LEN);

  typedef logic [CNT_W-1:0] len_t;
  typedef enum logic [1:0] {RC_NONE = 2'd0, RC_X1 = 2'd1, RC_X15 = 2'd2, RC_X2 = 2'd3} ratio_e;
  typedef enum logic [1:0] {S_HUNT, S_CONFIRM, S_ARMED, S_SYNC} mon_state_e;

  // nominal master clocks per word-clock period for each ratio code
  function automatic len_t nominal_len(ratio_e r);
    case (r)
      RC_X1:   return len_t'(256);
      RC_X15:  return len_t'(384);
      RC_X2:   return len_t'(RATIO_MAX_LEN);
      default: return '0;
    endcase
  endfunction

  function automatic len_t abs_diff(len_t a, len_t b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  function automatic ratio_e classify(len_t len, int tol);
    ratio_e hit = RC_NONE;
    if (abs_diff(len, nominal_len(RC_X1)) <= len_t'(tol))  hit = RC_X1;
    if (abs_diff(len, nominal_len(RC_X15)) <= len_t'(tol)) hit = RC_X15;
    if (abs_diff(len, nominal_len(RC_X2)) <= len_t'(tol))  hit = RC_X2;
    return hit;
  endfunction

  function automatic len_t drift_limit(int bits, int bit_len);
    return len_t'(bits * bit_len);
  endfunction

  // enable pattern position ph within the divide sequence
  function automatic logic rate_pattern(ratio_e r, logic [1:0] ph);
    case (r)
      RC_X1:   return 1'b1;
      RC_X15:  return ph != 2'd2;
      RC_X2:   return ph == 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] next_phase(ratio_e r, logic [1:0] ph);
    case (r)
      RC_X15:  return (ph == 2'd2) ? 2'd0 : ph + 2'd1;
      RC_X2:   return (ph == 2'd1) ? 2'd0 : 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/mrs_reset_seq.sv
module mrs_reset_seq #(
  parameter int INIT_CYCLES = 1024,
  parameter int ADC_FRAMES  = 4096
) (
  input  logic clk,
  input  logic hard_rst_n,
  input  logic frame_tick,
  output logic int_rst_n,
  output logic adc_ready
);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int AW = $clog2(ADC_FRAMES + 1);

  logic [IW-1:0] init_cnt;
  logic [AW-1:0] adc_cnt;

  always_ff @(posedge clk or negedge hard_rst_n) begin
    if (!hard_rst_n) begin
      init_cnt  <= '0;
      int_rst_n <= 1'b0;
    end else if (!int_rst_n) begin
      if (init_cnt == IW'(INIT_CYCLES - 1)) int_rst_n <= 1'b1;
      else                                  init_cnt  <= init_cnt + 1'b1;
    end
  end

  // ADC hold counts word-clock frames after the internal reset lifts
  always_ff @(posedge clk or negedge int_rst_n) begin
    if (!int_rst_n) begin
      adc_cnt   <= '0;
      adc_ready <= 1'b0;
    end else if (frame_tick && !adc_ready) begin
      if (adc_cnt == AW'(ADC_FRAMES - 1)) adc_ready <= 1'b1;
      else                                adc_cnt   <= adc_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mrs_frame_monitor.sv
module mrs_frame_monitor
  import mrs_pkg::*;
#(
  parameter int MATCH_TOL  = 2,
  parameter int DRIFT_BITS = 5,
  parameter int BIT_W      = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lrck,
  input  logic   bck,
  output logic   frame_tick,
  output ratio_e ratio,
  output logic   sync_ok,
  output logic   sync_lost
);
  logic             lr_q, bk_q, bit_tick, seen;
  len_t             per_cnt, meas, nom, lim, drift;
  logic [BIT_W-1:0] bc_cnt, bit_per;
  mon_state_e       state;
  ratio_e           cand, cls;
  logic             in_lock, too_far, overdue, drop;

  always_comb begin
    frame_tick = lrck & ~lr_q;
    bit_tick   = bck & ~bk_q;
    meas       = per_cnt + len_t'(1);
    nom        = nominal_len(ratio);
    lim        = drift_limit(DRIFT_BITS, int'(bit_per));
    drift      = abs_diff(meas, nom);
    cls        = classify(meas, MATCH_TOL);
    in_lock    = (state == S_ARMED) || (state == S_SYNC);
    too_far    = frame_tick && seen && (drift > lim);
    overdue    = !frame_tick && (meas > nom + lim);
    drop       = in_lock && (too_far || overdue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q      <= 1'b1;
      bk_q      <= 1'b1;
      per_cnt   <= '0;
      seen      <= 1'b0;
      bc_cnt    <= '0;
      bit_per   <= '0;
      state     <= S_HUNT;
      cand      <= RC_NONE;
      ratio     <= RC_NONE;
      sync_lost <= 1'b0;
    end else begin
      lr_q      <= lrck;
      bk_q      <= bck;
      sync_lost <= 1'b0;
      if (bit_tick) begin
        bit_per <= bc_cnt + 1'b1;
        bc_cnt  <= '0;
      end else if (bc_cnt != '1) begin
        bc_cnt <= bc_cnt + 1'b1;
      end
      if (frame_tick) begin
        per_cnt <= '0;
        seen    <= 1'b1;
      end else if (per_cnt != '1) begin
        per_cnt <= per_cnt + 1'b1;
      end
      if (drop) begin
        state     <= S_HUNT;
        cand      <= RC_NONE;
        ratio     <= RC_NONE;
        sync_lost <= 1'b1;
      end else if (frame_tick && seen) begin
        case (state)
          S_HUNT: if (cls != RC_NONE) begin
            cand  <= cls;
            state <= S_CONFIRM;
          end
          S_CONFIRM: begin
            if (cls != RC_NONE && cls == cand) begin
              ratio <= cls;
              state <= S_ARMED;
            end else if (cls != RC_NONE) begin
              cand <= cls;
            end else begin
              state <= S_HUNT;
            end
          end
          S_ARMED: state <= S_SYNC;
          default: state <= S_SYNC;
        endcase
      end
    end
  end

  assign sync_ok = (state == S_SYNC);
endmodule

// File: rtl/mrs_rate_enable.sv
module mrs_rate_enable
  import mrs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_e ratio,
  output logic   en
);
  ratio_e     code_q;
  logic [1:0] phase, ph_eff;

  always_comb begin
    ph_eff = (ratio != code_q) ? 2'd0 : phase;
    en     = rate_pattern(ratio, ph_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RC_NONE;
      phase  <= 2'd0;
    end else begin
      code_q <= ratio;
      phase  <= next_phase(ratio, ph_eff);
    end
  end
endmodule

// File: rtl/mclk_ratio_sync.sv
module mclk_ratio_sync
  import mrs_pkg::*;
#(
  parameter int INIT_CYCLES = 1024,
  parameter int ADC_FRAMES  = 4096,
  parameter int MATCH_TOL   = 2,
  parameter int DRIFT_BITS  = 5,
  parameter int BIT_W       = 8
) (
  input  logic       mclk,
  input  logic       power_good,
  input  logic       rst_pin_n,
  input  logic       lrck,
  input  logic       bck,
  output logic [1:0] ratio_code,
  output logic       en_256fs,
  output logic       int_rst_n,
  output logic       dac_force_mid,
  output logic       adc_force_zero,
  output logic       sync_ok,
  output logic       sync_lost
);
  logic   hard_rst_n, frame_tick, adc_ready;
  ratio_e ratio_q;

  assign hard_rst_n = power_good & rst_pin_n;

  mrs_reset_seq #(.INIT_CYCLES(INIT_CYCLES), .ADC_FRAMES(ADC_FRAMES)) u_rst (
    .clk(mclk), .hard_rst_n(hard_rst_n), .frame_tick(frame_tick),
    .int_rst_n(int_rst_n), .adc_ready(adc_ready)
  );

  mrs_frame_monitor #(.MATCH_TOL(MATCH_TOL), .DRIFT_BITS(DRIFT_BITS), .BIT_W(BIT_W)) u_mon (
    .clk(mclk), .rst_n(int_rst_n), .lrck(lrck), .bck(bck),
    .frame_tick(frame_tick), .ratio(ratio_q), .sync_ok(sync_ok), .sync_lost(sync_lost)
  );

  mrs_rate_enable u_en (
    .clk(mclk), .rst_n(int_rst_n), .ratio(ratio_q), .en(en_256fs)
  );

  assign ratio_code     = ratio_q;
  assign dac_force_mid  = !int_rst_n || !sync_ok;
  assign adc_force_zero = dac_force_mid || !adc_ready;
endmodule

// File: rtl/mclk_ratio_sync_chk.sv
module mclk_ratio_sync_chk (
  input logic       mclk,
  input logic       power_good,
  input logic       rst_pin_n,
  input logic       frame_tick,
  input logic       int_rst_n,
  input logic [1:0] ratio_code,
  input logic       en_256fs,
  input logic       dac_force_mid,
  input logic       adc_force_zero,
  input logic       sync_ok,
  input logic       sync_lost
);
  logic hard_rst_n;
  assign hard_rst_n = power_good & rst_pin_n;

  p_release_holds_r1: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    int_rst_n |=> int_rst_n);
  p_init_forces_r2: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    !int_rst_n |-> (dac_force_mid && adc_force_zero && ratio_code == 2'd0 && !en_256fs));
  p_sync_has_ratio_r4: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    sync_ok |-> ratio_code != 2'd0);
  p_release_on_frame_r4: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    $rose(sync_ok) |-> $past(frame_tick));
  p_adc_after_dac_r5: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    !adc_force_zero |-> !dac_force_mid);
  p_lost_single_r6: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    sync_lost |=> !sync_lost);
  p_lost_clears_r6: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    sync_lost |-> (!sync_ok && ratio_code == 2'd0 && dac_force_mid));
  p_x1_rate_r8: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    ratio_code == 2'd1 |-> en_256fs);
  p_x15_rate_r8: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    (ratio_code == 2'd2 && $past(ratio_code) == 2'd2 && $past(ratio_code, 2) == 2'd2)
    |-> $countones({en_256fs, $past(en_256fs), $past(en_256fs, 2)}) == 2);
  p_x2_rate_r8: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    (ratio_code == 2'd3 && $past(ratio_code) == 2'd3) |-> en_256fs != $past(en_256fs));
  p_none_rate_r8: assert property (@(posedge mclk) disable iff (!hard_rst_n)
    ratio_code == 2'd0 |-> !en_256fs);
endmodule

bind mclk_ratio_sync mclk_ratio_sync_chk u_chk (
  .mclk(mclk), .power_good(power_good), .rst_pin_n(rst_pin_n), .frame_tick(frame_tick),
  .int_rst_n(int_rst_n), .ratio_code(ratio_code), .en_256fs(en_256fs),
  .dac_force_mid(dac_force_mid), .adc_force_zero(adc_force_zero),
  .sync_ok(sync_ok), .sync_lost(sync_lost)
);

// File: tb/mclk_ratio_sync_test.sv
`timescale 1ns/1ps
module mclk_ratio_sync_test;
  localparam int INIT = 16;
  localparam int ADCF = 8;

  logic       mclk, power_good, rst_pin_n, lrck, bck;
  logic [1:0] ratio_code;
  logic       en_256fs, int_rst_n, dac_force_mid, adc_force_zero, sync_ok, sync_lost;

  int tests = 0, fails = 0;
  int P = 256, BH = 2, shift_once = 0, cur_len = 256, mc = 0, bc = 0;
  int rises = 0, lost_count = 0;
  logic prev_lr = 1'b1;

  mclk_ratio_sync #(.INIT_CYCLES(INIT), .ADC_FRAMES(ADCF), .MATCH_TOL(2), .DRIFT_BITS(5)) uut (
    .mclk(mclk), .power_good(power_good), .rst_pin_n(rst_pin_n), .lrck(lrck), .bck(bck),
    .ratio_code(ratio_code), .en_256fs(en_256fs), .int_rst_n(int_rst_n),
    .dac_force_mid(dac_force_mid), .adc_force_zero(adc_force_zero),
    .sync_ok(sync_ok), .sync_lost(sync_lost)
  );

  initial mclk = 1'b0;
  always #4 mclk = ~mclk;

  // word and bit clock generator, changes on falling edges only
  initial begin lrck = 1'b0; bck = 1'b0; end
  always @(negedge mclk) begin
    mc = (mc + 1 >= cur_len) ? 0 : mc + 1;
    if (mc == 0) begin
      cur_len = P + shift_once;
      shift_once = 0;
    end
    lrck = (mc < P / 2);
    bc = (bc + 1 >= BH) ? 0 : bc + 1;
    if (bc == 0) bck = ~bck;
  end

  // word-clock rising edges the block can see after internal reset lifts
  always @(posedge mclk) begin
    if (!int_rst_n) begin
      rises = 0;
      prev_lr = 1'b1;
    end else begin
      if (lrck && !prev_lr) rises++;
      prev_lr = lrck;
    end
    if (sync_lost) lost_count++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rises(input int n);
    while (rises < n) @(negedge mclk);
    #1;
  endtask

  task automatic count_en(output int n);
    n = 0;
    repeat (12) begin
      @(negedge mclk); #1;
      n += int'(en_256fs);
    end
  endtask

  task automatic t_reset_release;
    @(negedge mclk); rst_pin_n = 1'b0; #1;
    chk("R1 reset pin low", int'(int_rst_n), 0);
    chk("R2 dac forced in reset", int'(dac_force_mid), 1);
    chk("R2 adc forced in reset", int'(adc_force_zero), 1);
    chk("R2 ratio none in reset", int'(ratio_code), 0);
    chk("R2 no enable in reset", int'(en_256fs), 0);
    repeat (3) @(negedge mclk);
    rst_pin_n = 1'b1;
    repeat (INIT - 1) @(posedge mclk);
    @(negedge mclk); #1;
    chk("R1 held one edge early", int'(int_rst_n), 0);
    @(posedge mclk); @(negedge mclk); #1;
    chk("R1 released on count", int'(int_rst_n), 1);
  endtask

  task automatic t_lock_sequence;
    wait_rises(3);
    chk("R4 ratio at second match", int'(ratio_code), 1);
    chk("R4 dac still forced", int'(dac_force_mid), 1);
    wait_rises(4);
    chk("R4 sync on next frame", int'(sync_ok), 1);
    chk("R4 dac released", int'(dac_force_mid), 0);
    chk("R5 adc held by frames", int'(adc_force_zero), 1);
    wait_rises(ADCF - 1);
    chk("R5 adc held one frame early", int'(adc_force_zero), 1);
    wait_rises(ADCF);
    chk("R5 adc released", int'(adc_force_zero), 0);
  endtask

  task automatic t_rate1;
    int n;
    count_en(n);
    chk("R8 x1 enable every cycle", n, 12);
  endtask

  task automatic t_drift_ok;
    int r0, l0;
    @(posedge mclk); shift_once = 20;
    @(negedge mclk); #1; r0 = rises; l0 = lost_count;
    wait_rises(r0 + 3);
    chk("R6 drift 5 bits keeps sync", int'(sync_ok), 1);
    chk("R6 no loss pulse", lost_count, l0);
  endtask

  task automatic t_drift_bad;
    int r0, l0;
    @(posedge mclk); shift_once = -24;
    @(negedge mclk); #1; r0 = rises; l0 = lost_count;
    wait_rises(r0 + 2);
    chk("R6 drift 6 bits drops sync", int'(sync_ok), 0);
    chk("R6 ratio cleared", int'(ratio_code), 0);
    chk("R6 dac forced", int'(dac_force_mid), 1);
    chk("R6 adc forced", int'(adc_force_zero), 1);
    wait_rises(r0 + 3);
    chk("R6 single loss pulse", lost_count, l0 + 1);
    wait_rises(r0 + 4);
    chk("R4 relock ratio", int'(ratio_code), 1);
    chk("R4 relock not yet released", int'(sync_ok), 0);
    wait_rises(r0 + 5);
    chk("R4 relock released", int'(sync_ok), 1);
  endtask

  task automatic t_overdue;
    int r0;
    @(posedge mclk); shift_once = 24;
    @(negedge mclk); #1; r0 = rises;
    wait_rises(r0 + 1);
    repeat (276) @(negedge mclk);
    #1;
    chk("R7 in sync at limit", int'(sync_ok), 1);
    @(negedge mclk); #1;
    chk("R7 loss before late edge", int'(sync_ok), 0);
    chk("R7 loss pulse", int'(sync_lost), 1);
    wait_rises(r0 + 5);
    chk("R7 relocked", int'(sync_ok), 1);
  endtask

  task automatic t_tolerance;
    int r0, n;
    @(posedge mclk); P = 300;
    @(negedge mclk); #1; r0 = rises;
    wait_rises(r0 + 6);
    chk("R3 length 300 no lock", int'(sync_ok), 0);
    chk("R3 length 300 code none", int'(ratio_code), 0);
    count_en(n);
    chk("R8 no enable without ratio", n, 0);
    @(posedge mclk); P = 259;
    @(negedge mclk); #1; r0 = rises;
    wait_rises(r0 + 6);
    chk("R3 length 259 no lock", int'(ratio_code), 0);
    @(posedge mclk); P = 258;
    @(negedge mclk); #1; r0 = rises;
    wait_rises(r0 + 6);
    chk("R3 length 258 locks", int'(ratio_code), 1);
    chk("R3 length 258 in sync", int'(sync_ok), 1);
    @(posedge mclk); P = 256;
    @(negedge mclk); #1; r0 = rises;
    wait_rises(r0 + 3);
    chk("R6 small step keeps sync", int'(sync_ok), 1);
  endtask

  task automatic t_ratio(input int len, input int bh, input int code, input int en_exp);
    int r0, n, guard;
    @(posedge mclk); P = len; BH = bh;
    guard = 0;
    @(negedge mclk); #1;
    while (ratio_code != 2'd0 && guard < 5000) begin @(negedge mclk); #1; guard++; end
    while (ratio_code == 2'd0 && guard < 20000) begin @(negedge mclk); #1; guard++; end
    chk("R8 pattern restarts high", int'(en_256fs), 1);
    r0 = rises;
    wait_rises(r0 + 2);
    chk("R3 detected code", int'(ratio_code), code);
    chk("R4 in sync", int'(sync_ok), 1);
    count_en(n);
    chk("R8 enable density", n, en_exp);
  endtask

  task automatic t_power_good;
    @(negedge mclk); power_good = 1'b0; #1;
    chk("R1 power loss resets", int'(int_rst_n), 0);
    chk("R2 dac forced on power loss", int'(dac_force_mid), 1);
    chk("R2 adc forced on power loss", int'(adc_force_zero), 1);
    chk("R2 ratio none on power loss", int'(ratio_code), 0);
    @(negedge mclk); power_good = 1'b1;
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    power_good = 1'b1;
    rst_pin_n  = 1'b0;
    repeat (4) @(negedge mclk);
    t_reset_release();
    t_lock_sequence();
    t_rate1();
    t_drift_ok();
    t_drift_bad();
    t_overdue();
    t_tolerance();
    t_ratio(384, 3, 2, 8);
    t_ratio(512, 4, 3, 6);
    t_power_good();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule